// File: doc/BRIEF.md
# Video Pixel Serializer

The serializer turns words fetched from display memory into a serial pixel stream. An external timing generator pulls an active-low load strobe at the moment a freshly fetched word sits on the data input; on that clock edge the word is captured in a shift register. From then on one bit leaves per pixel clock, most significant bit first. Each outgoing bit passes an output gate before it reaches the single-bit video output. The gate applies a polarity control through an XNOR, then ANDs the result with an enable.

Blanking overrides everything. While the blank input is high, the output is dark and load strobes are not taken. If the timing generator supplies no new word after a full word has been shifted, the register keeps shifting zeros. Those zeros still pass through the polarity and enable gate, so an inverted display shows light pixels in that gap.

Top module: `vps_serializer`

## Requirements
- R1: After reset the shift register holds all zeros, so with enable_i=1, invert_i=1 and blank_i=0 the output video_o is 0.
- R2: On a clock edge where load_ni=0 and blank_i=0, word_i is captured, and its bit 15 drives the pixel bit in the following cycle.
- R3: On each clock edge without a capture the register shifts by one toward the MSB, so the captured bits appear in order from bit 15 down to bit 0, one per clock.
- R4: While blank_i=0, video_o equals (pixel bit XNOR invert_i) AND enable_i: invert_i=1 passes the bit unchanged and invert_i=0 complements it.
- R5: While enable_i=0, video_o is 0 for any pixel bit and any invert_i.
- R6: While blank_i=1, video_o is 0 for any pixel bit, invert_i and enable_i.
- R7: A load strobe on an edge where blank_i=1 is ignored, and the register shifts as if no strobe were present.
- R8: When 16 or more shifts pass with no capture, the pixel bit is 0, and it still goes through the R4 gate, so invert_i=0 with enable_i=1 gives video_o=1.
- R9: A capture replaces the register contents at any shift position. A strobe on the edge right after bit 0 is shown places the new word's bit 15 in the very next pixel slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 16 | Word fetched from display memory |
| load_ni | input | 1 | Capture strobe from the timing generator, active low |
| blank_i | input | 1 | High during horizontal or vertical blanking |
| enable_i | input | 1 | Video enable; 0 forces a dark output |
| invert_i | input | 1 | Polarity select for the XNOR stage |
| video_o | output | 1 | Serial pixel output |

## Verification
The assertions assume the control inputs change only between clock edges. They also assume the drain counter reflects true shift counts, which holds only if reset precedes any load. They do not assume that strobes are spaced a full word apart, because R9 allows early reloads. The random stimulus therefore drives strobes at any spacing, toggles blanking, polarity and enable freely, and changes inputs only on the falling edge. Directed sequences cover a full sixteen-bit drain into zeros, a strobe exactly after bit 0, a strobe in mid-word and a strobe during blanking.

// File: rtl/vps_pkg.sv
package vps_pkg;
  localparam int unsigned WORD_W_DEF = 16;
  localparam bit          MSB_FIRST_DEF = 1'b1;
endpackage

// File: rtl/vps_load_ctrl.sv
module vps_load_ctrl #(
  parameter int unsigned WORD_W = vps_pkg::WORD_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_ni,
  input  logic blank_i,
  output logic load_en_o,
  output logic drained_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0] shift_cnt_q;

  // strobes inside blanking are dropped
  assign load_en_o = ~load_ni & ~blank_i;
  assign drained_o = (shift_cnt_q == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                shift_cnt_q <= CNT_FULL;
    else if (load_en_o)         shift_cnt_q <= '0;
    else if (!drained_o)        shift_cnt_q <= shift_cnt_q + 1'b1;
  end

  assert_blank_blocks_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && !load_ni) |=> (shift_cnt_q != '0 || $past(shift_cnt_q) == CNT_FULL - 1'b1 || $past(shift_cnt_q) == CNT_FULL));

  assert_cnt_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_cnt_q <= CNT_FULL);
endmodule

// File: rtl/vps_shifter.sv
module vps_shifter #(
  parameter int unsigned WORD_W    = vps_pkg::WORD_W_DEF,
  parameter bit          MSB_FIRST = vps_pkg::MSB_FIRST_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_shifted;

  generate
    if (MSB_FIRST) begin : g_msb
      assign sr_shifted = {sr_q[WORD_W-2:0], 1'b0};
      assign bit_o      = sr_q[WORD_W-1];

      assert_load_msb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_en_i |=> bit_o == $past(word_i[WORD_W-1]));
      assert_shift_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_en_i |=> bit_o == $past(sr_q[WORD_W-2]));
    end else begin : g_lsb
      assign sr_shifted = {1'b0, sr_q[WORD_W-1:1]};
      assign bit_o      = sr_q[0];

      assert_load_lsb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_en_i |=> bit_o == $past(word_i[0]));
      assert_shift_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_en_i |=> bit_o == $past(sr_q[1]));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (load_en_i) sr_q <= word_i;
    else                sr_q <= sr_shifted;
  end
endmodule

// File: rtl/vps_pixel_gate.sv
module vps_pixel_gate (
  input  logic bit_i,
  input  logic invert_i,
  input  logic enable_i,
  input  logic blank_i,
  output logic pix_o
);
  logic pol_bit;

  assign pol_bit = ~(bit_i ^ invert_i);
  assign pix_o   = pol_bit & enable_i & ~blank_i;

  always_comb begin
    assert_dark_when_off_R5: assert (enable_i || !pix_o);
    assert_dark_in_blank_R6: assert (!blank_i || !pix_o);
  end
endmodule

// File: rtl/vps_serializer.sv
module vps_serializer #(
  parameter int unsigned WORD_W    = vps_pkg::WORD_W_DEF,
  parameter bit          MSB_FIRST = vps_pkg::MSB_FIRST_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_ni,
  input  logic              blank_i,
  input  logic              enable_i,
  input  logic              invert_i,
  output logic              video_o
);
  logic load_en;
  logic drained;
  logic pix_bit;

  vps_load_ctrl #(.WORD_W(WORD_W)) u_load_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_ni   (load_ni),
    .blank_i   (blank_i),
    .load_en_o (load_en),
    .drained_o (drained)
  );

  vps_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_en_i (load_en),
    .word_i    (word_i),
    .bit_o     (pix_bit)
  );

  vps_pixel_gate u_gate (
    .bit_i    (pix_bit),
    .invert_i (invert_i),
    .enable_i (enable_i),
    .blank_i  (blank_i),
    .pix_o    (video_o)
  );

  assert_zero_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drained |-> !pix_bit);

  assert_gate_passes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !blank_i) |-> (video_o == (pix_bit ~^ invert_i)));

  assert_reload_any_pos_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> !drained);
endmodule

// File: tb/vps_serializer_tb.sv
module vps_serializer_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         load_ni = 1'b1;
  logic         blank_i = 1'b0;
  logic         enable_i = 1'b1;
  logic         invert_i = 1'b1;
  logic         video_o;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] m_sr = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vps_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .load_ni(load_ni),
    .blank_i(blank_i), .enable_i(enable_i), .invert_i(invert_i), .video_o(video_o)
  );

  function automatic logic exp_pix(logic b, logic inv, logic en, logic bl);
    return bl ? 1'b0 : ((b ~^ inv) & en);
  endfunction

  task automatic check(string tag);
    logic e;
    e = exp_pix(m_sr[W-1], invert_i, enable_i, blank_i);
    checks++;
    if (video_o !== e) begin
      errors++;
      $display("FAIL %s: video_o=%b expected=%b (sr=%h inv=%b en=%b bl=%b)",
               tag, video_o, e, m_sr, invert_i, enable_i, blank_i);
    end
  endtask

  // drive at negedge, check mid-low phase, then advance model at posedge
  task automatic step(logic [W-1:0] w, logic ld_n, logic bl, logic en, logic inv, string tag);
    @(negedge clk);
    word_i = w; load_ni = ld_n; blank_i = bl; enable_i = en; invert_i = inv;
    #2;
    check(tag);
    @(posedge clk);
    if (!ld_n && !bl) m_sr = w;
    else              m_sr = {m_sr[W-2:0], 1'b0};
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #2;
    check("R1");
    // R2 R3 R4: full word, pass-through polarity
    step(16'hA5C3, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
    for (int i = 0; i < W; i++) step('0, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    // R8: drained register with invert_i=0 lights pixels
    for (int i = 0; i < 4; i++) step('0, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
    // R4 complement polarity
    step(16'h3C96, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    for (int i = 0; i < W - 1; i++) step('0, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
    // R9: strobe right after bit 0
    step(16'hF00F, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    step(16'h8001, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    // R9 mid-word reload
    for (int i = 0; i < 5; i++) step('0, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    step(16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 3; i++) step('0, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    // R5 enable low, both polarities
    for (int i = 0; i < 4; i++) step('0, 1'b1, 1'b0, 1'b0, i[0], "R5");
    // R6 and R7: strobe during blanking is dropped
    step(16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 4; i++) step('0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    for (int i = 0; i < W; i++) step('0, 1'b1, 1'b0, 1'b1, 1'b1, "R7");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] w;
      w = W'($urandom);
      step(w, ($urandom % 8) != 0, ($urandom % 6) == 0, ($urandom % 5) != 0,
           1'($urandom), "R4");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule